// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Threshold and Trailing Interrupts

This block holds the transmit and receive byte queues that sit between a simple register bus and an I2C bus engine. Software writes outgoing bytes into the transmit queue and reads incoming bytes from the receive queue. The engine drains the transmit queue and fills the receive queue through single-cycle pop and push strobes. The queue depth is a parameter and may be 16 or 64 bytes.

Each queue has a programmable trigger level. The transmit side asks for more data when its fill is at or below its trigger. The receive side asks to be drained when its fill is at or above its trigger. A trailing timer catches a short tail of received bytes that never reaches the trigger: it raises its own flag after the receive side has been idle for a programmable count of cycles. Pushing into a full queue or popping an empty one raises a per-queue overrun or underrun flag. All flags are sticky and are cleared by writing 1. A single interrupt line is the OR of the flags that are pending and enabled.

Top module: `xfer_fifo_irq`

## Requirements
- R1: After reset both queues are disabled and empty, the control, limit, enable and status registers read zero, the queue status word reads 0x0100_0100, and `irq` is low.
- R2: Bytes leave each queue in the order they entered, with no loss. The queue status word (address 4) holds the TX fill at bits 6:0, TX full at bit 7, TX empty at bit 8, the RX fill at bits 22:16, RX full at bit 23 and RX empty at bit 24. Full means the fill equals the DEPTH parameter.
- R3: The control register (address 0) holds the RX enable at bit 0, the TX enable at bit 1, the RX trigger at bits 10:4 and the TX trigger at bits 22:16. Clearing an enable empties that queue on the same clock edge as the write. While a queue is disabled, its pushes and pops are ignored and raise no flag.
- R4: A push into a full queue drops the byte. It sets TX overrun (status bit 3) for a write to address 5, or RX overrun (bit 5) for an engine push. A push and a pop in the same cycle on a full queue are both accepted, and no overrun is raised.
- R5: A pop from an empty queue reads zero. It sets TX underrun (bit 2) for an engine pop, or RX underrun (bit 4) for a read of address 6. A push and a pop in the same cycle on an empty queue store the byte and still raise underrun.
- R6: Suppose the RX fill is between 1 and the RX trigger minus 1, and the RX side sees neither an engine push nor a data read for L+1 consecutive cycles, where L is the limit register (address 1, bits 3:0). Then trailing (bit 6) is set one edge later. Any RX push or read restarts the count.
- R7: TX almost-empty (bit 0) is set on every edge where the enabled TX fill was at or below the TX trigger. RX almost-full (bit 1) is set on every edge where the enabled RX fill was at or above the RX trigger.
- R8: Writing the status register (address 3) clears the bits written as 1 and leaves the bits written as 0 untouched. If a bit's set condition holds in the same cycle as its clear, the bit stays set.
- R9: `irq` is high exactly when some status bit is 1 and the same bit of the enable register (address 2, bits 6:0) is 1.
- R10: A register read returns the current contents without side effects, except a read of address 6, which pops one RX byte. Address 5 and address 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops RX at address 6) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| eng_tx_pop | input | 1 | Engine takes the TX head byte |
| eng_tx_data | output | 8 | TX head byte, zero when empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| irq | output | 1 | OR of enabled pending status bits |

## Verification
Two events can hit the same status bit in one cycle: a level or error event that sets the bit, and a write-1-to-clear from software. The bench provokes this collision in a directed case by clearing almost-empty while the TX queue sits below its trigger. The bit must read back as 1. The random phase also produces the collision freely. Queue pushes and pops collide too, on a full queue and on an empty one. These collisions are judged against a cycle-level model, which checks overrun, underrun and fill on each edge.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
   localparam int FLD_W = 7;
   localparam int NIRQ  = 7;

   localparam logic [2:0] A_CTRL  = 3'd0;
   localparam logic [2:0] A_TRAIL = 3'd1;
   localparam logic [2:0] A_IEN   = 3'd2;
   localparam logic [2:0] A_ISTAT = 3'd3;
   localparam logic [2:0] A_FSTAT = 3'd4;
   localparam logic [2:0] A_TXD   = 3'd5;
   localparam logic [2:0] A_RXD   = 3'd6;

   localparam int I_TXAE  = 0;
   localparam int I_RXAF  = 1;
   localparam int I_TXUR  = 2;
   localparam int I_TXOR  = 3;
   localparam int I_RXUR  = 4;
   localparam int I_RXOR  = 5;
   localparam int I_TRAIL = 6;

   localparam int C_RXEN   = 0;
   localparam int C_TXEN   = 1;
   localparam int C_RXTRIG = 4;
   localparam int C_TXTRIG = 16;

   localparam int S_TXLVL   = 0;
   localparam int S_TXFULL  = 7;
   localparam int S_TXEMPTY = 8;
   localparam int S_RXLVL   = 16;
   localparam int S_RXFULL  = 23;
   localparam int S_RXEMPTY = 24;
endpackage

// File: rtl/xfer_fifo_queue.sv
module xfer_fifo_queue #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty,
   output logic          overrun,
   output logic          underrun
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_depth_pow2
         $error("xfer_fifo_queue: DEPTH must be a power of two");
      end
   endgenerate

   logic [DW-1:0] mem_q [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic [LW-1:0] level_q;
   logic          take, put;

   assign full     = (level_q == LW'(DEPTH));
   assign empty    = (level_q == '0);
   assign take     = pop & ~empty;
   assign put      = push & (~full | take);
   assign overrun  = push & full & ~take;
   assign underrun = pop & empty;
   assign head     = empty ? '0 : mem_q[rd_q];
   assign level    = level_q;

   always_ff @(posedge clk) begin
      if (put) mem_q[wr_q] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_q    <= '0;
         rd_q    <= '0;
         level_q <= '0;
      end else begin
         if (put)  wr_q <= wr_q + 1'b1;
         if (take) rd_q <= rd_q + 1'b1;
         level_q <= level_q + LW'(put) - LW'(take);
      end
   end

   assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LW'(DEPTH));
   assert_overrun_keeps_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !flush) |=> full);
   assert_underrun_stays_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !push && !flush) |=> empty);
endmodule

// File: rtl/xfer_fifo_trail.sv
module xfer_fifo_trail #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          armed,
   input  logic          activity,
   input  logic [CW-1:0] limit,
   output logic          fire
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !armed || activity) cnt_q <= '0;
      else if (cnt_q != limit)          cnt_q <= cnt_q + 1'b1;
   end

   assign fire = armed & ~activity & (cnt_q == limit);

   assert_trail_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed || activity) |=> (cnt_q == '0));
endmodule

// File: rtl/xfer_fifo_irqctl.sv
module xfer_fifo_irqctl #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         clr_we,
   input  logic [N-1:0] clr_mask,
   input  logic         en_we,
   input  logic [N-1:0] en_data,
   output logic [N-1:0] stat,
   output logic [N-1:0] en,
   output logic         irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)     en <= '0;
      else if (en_we) en <= en_data;
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                     bit_q <= 1'b0;
            else if (set_vec[i])            bit_q <= 1'b1;
            else if (clr_we && clr_mask[i]) bit_q <= 1'b0;
         end
         assign stat[i] = bit_q;

         assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> stat[i]);
         assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[i] && !set_vec[i]) |=> !stat[i]);
      end
   endgenerate

   assign irq = |(stat & en);
endmodule

// File: rtl/xfer_fifo_irq.sv
module xfer_fifo_irq
   import xfer_fifo_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int TRAIL_W = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic        reg_re,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        eng_tx_pop,
   output logic [7:0]  eng_tx_data,
   input  logic        eng_rx_push,
   input  logic [7:0]  eng_rx_data,
   output logic        irq
);
   localparam int LW = $clog2(DEPTH) + 1;

   generate
      if (DEPTH != 16 && DEPTH != 64) begin : g_depth_chk
         $error("xfer_fifo_irq: DEPTH must be 16 or 64");
      end
      if (TRAIL_W < 1 || TRAIL_W > 8) begin : g_trail_chk
         $error("xfer_fifo_irq: TRAIL_W out of range");
      end
   endgenerate

   logic             rx_en_q, tx_en_q, rx_en_d, tx_en_d;
   logic [FLD_W-1:0] rx_trig_q, tx_trig_q;
   logic [TRAIL_W-1:0] trail_q;
   logic             ctrl_wr;

   assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
   assign rx_en_d = ctrl_wr ? reg_wdata[C_RXEN] : rx_en_q;
   assign tx_en_d = ctrl_wr ? reg_wdata[C_TXEN] : tx_en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_en_q   <= 1'b0;
         tx_en_q   <= 1'b0;
         rx_trig_q <= '0;
         tx_trig_q <= '0;
         trail_q   <= '0;
      end else begin
         rx_en_q <= rx_en_d;
         tx_en_q <= tx_en_d;
         if (ctrl_wr) begin
            rx_trig_q <= reg_wdata[C_RXTRIG +: FLD_W];
            tx_trig_q <= reg_wdata[C_TXTRIG +: FLD_W];
         end
         if (reg_we && reg_addr == A_TRAIL) trail_q <= reg_wdata[TRAIL_W-1:0];
      end
   end

   logic          tx_push, tx_pop, rx_push, rx_pop;
   logic [LW-1:0] tx_lvl, rx_lvl;
   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic          tx_or, tx_ur, rx_or, rx_ur;
   logic [7:0]    rx_head;

   assign tx_push = tx_en_q & reg_we & (reg_addr == A_TXD);
   assign tx_pop  = tx_en_q & eng_tx_pop;
   assign rx_push = rx_en_q & eng_rx_push;
   assign rx_pop  = rx_en_q & reg_re & (reg_addr == A_RXD);

   xfer_fifo_queue #(.DEPTH(DEPTH), .DW(8)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(!tx_en_d),
      .push(tx_push), .push_data(reg_wdata[7:0]), .pop(tx_pop),
      .head(eng_tx_data), .level(tx_lvl), .full(tx_full), .empty(tx_empty),
      .overrun(tx_or), .underrun(tx_ur));

   xfer_fifo_queue #(.DEPTH(DEPTH), .DW(8)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(!rx_en_d),
      .push(rx_push), .push_data(eng_rx_data), .pop(rx_pop),
      .head(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty),
      .overrun(rx_or), .underrun(rx_ur));

   logic [FLD_W-1:0] tx_lvl_x, rx_lvl_x;
   assign tx_lvl_x = FLD_W'(tx_lvl);
   assign rx_lvl_x = FLD_W'(rx_lvl);

   logic trail_armed, trail_fire;
   assign trail_armed = rx_en_q && (rx_lvl_x != '0) && (rx_lvl_x < rx_trig_q);

   xfer_fifo_trail #(.CW(TRAIL_W)) u_trail (
      .clk(clk), .rst_n(rst_n), .armed(trail_armed),
      .activity(rx_push | rx_pop), .limit(trail_q), .fire(trail_fire));

   logic [NIRQ-1:0] set_vec, stat, ien;
   always_comb begin
      set_vec          = '0;
      set_vec[I_TXAE]  = tx_en_q && (tx_lvl_x <= tx_trig_q);
      set_vec[I_RXAF]  = rx_en_q && (rx_lvl_x >= rx_trig_q);
      set_vec[I_TXUR]  = tx_ur;
      set_vec[I_TXOR]  = tx_or;
      set_vec[I_RXUR]  = rx_ur;
      set_vec[I_RXOR]  = rx_or;
      set_vec[I_TRAIL] = trail_fire;
   end

   xfer_fifo_irqctl #(.N(NIRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
      .clr_we(reg_we && reg_addr == A_ISTAT), .clr_mask(reg_wdata[NIRQ-1:0]),
      .en_we(reg_we && reg_addr == A_IEN), .en_data(reg_wdata[NIRQ-1:0]),
      .stat(stat), .en(ien), .irq(irq));

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[C_RXEN]            = rx_en_q;
            reg_rdata[C_TXEN]            = tx_en_q;
            reg_rdata[C_RXTRIG +: FLD_W] = rx_trig_q;
            reg_rdata[C_TXTRIG +: FLD_W] = tx_trig_q;
         end
         A_TRAIL: reg_rdata[TRAIL_W-1:0] = trail_q;
         A_IEN:   reg_rdata[NIRQ-1:0]    = ien;
         A_ISTAT: reg_rdata[NIRQ-1:0]    = stat;
         A_FSTAT: begin
            reg_rdata[S_TXLVL +: FLD_W] = tx_lvl_x;
            reg_rdata[S_TXFULL]         = tx_full;
            reg_rdata[S_TXEMPTY]        = tx_empty;
            reg_rdata[S_RXLVL +: FLD_W] = rx_lvl_x;
            reg_rdata[S_RXFULL]         = rx_full;
            reg_rdata[S_RXEMPTY]        = rx_empty;
         end
         A_RXD:   reg_rdata[7:0] = rx_head;
         default: reg_rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata[31:23], reg_wdata[15:11]};

   assert_trail_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trail_fire |-> !rx_empty);
endmodule

// File: tb/xfer_fifo_irq_tb.sv
`timescale 1ns/1ps
module xfer_fifo_irq_tb;
   import xfer_fifo_pkg::*;
   localparam int D = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_we, reg_re, eng_tx_pop, eng_rx_push, irq;
   logic [2:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [7:0]  eng_tx_data, eng_rx_data;

   always #2.5 clk = ~clk;

   xfer_fifo_irq #(.DEPTH(D), .TRAIL_W(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .irq(irq));

   int n_chk = 0;
   int n_err = 0;

   logic [7:0] mtx[$];
   logic [7:0] mrx[$];
   bit         m_txen, m_rxen;
   logic [6:0] m_txtrig, m_rxtrig, m_ien, m_stat;
   logic [3:0] m_trail, m_tcnt;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [2:0] a);
      logic [31:0] r;
      r = '0;
      case (a)
         A_CTRL: begin r[0] = m_rxen; r[1] = m_txen; r[10:4] = m_rxtrig; r[22:16] = m_txtrig; end
         A_TRAIL: r[3:0] = m_trail;
         A_IEN:   r[6:0] = m_ien;
         A_ISTAT: r[6:0] = m_stat;
         A_FSTAT: begin
            r[6:0]   = 7'(mtx.size());
            r[7]     = (mtx.size() == D);
            r[8]     = (mtx.size() == 0);
            r[22:16] = 7'(mrx.size());
            r[23]    = (mrx.size() == D);
            r[24]    = (mrx.size() == 0);
         end
         A_RXD: r[7:0] = (mrx.size() > 0) ? mrx[0] : 8'h00;
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic cyc(input string tag, input bit we, input bit re, input logic [2:0] a,
                      input logic [31:0] wd, input bit tp, input bit rp, input logic [7:0] rd);
      int txn, rxn;
      logic [6:0] setv, clrm;
      bit tpush, rpop, take, put, cond, act;
      @(negedge clk);
      reg_we = we; reg_re = re; reg_addr = a; reg_wdata = wd;
      eng_tx_pop = tp; eng_rx_push = rp; eng_rx_data = rd;
      #1;
      chk("R9 irq", {31'b0, irq}, {31'b0, |(m_stat & m_ien)});
      if (re) chk({tag, " read"}, reg_rdata, exp_read(a));
      if (tp) chk("R2/R5 tx head", {24'b0, eng_tx_data},
                  {24'b0, (m_txen && mtx.size() > 0) ? mtx[0] : 8'h00});
      txn = mtx.size(); rxn = mrx.size();
      setv = '0;
      tpush = we && (a == A_TXD);
      rpop  = re && (a == A_RXD);
      if (m_txen) begin
         setv[0] = (txn <= m_txtrig);
         take = tp && txn > 0;
         put  = tpush && (txn < D || take);
         setv[2] = tp && txn == 0;
         setv[3] = tpush && txn == D && !take;
         if (take) void'(mtx.pop_front());
         if (put) mtx.push_back(wd[7:0]);
      end
      cond = m_rxen && rxn != 0 && rxn < m_rxtrig;
      act  = m_rxen && (rp || rpop);
      if (!cond || act) m_tcnt = 0;
      else begin
         setv[6] = (m_tcnt == m_trail);
         if (m_tcnt != m_trail) m_tcnt = m_tcnt + 1;
      end
      if (m_rxen) begin
         setv[1] = (rxn >= m_rxtrig);
         take = rpop && rxn > 0;
         put  = rp && (rxn < D || take);
         setv[4] = rpop && rxn == 0;
         setv[5] = rp && rxn == D && !take;
         if (take) void'(mrx.pop_front());
         if (put) mrx.push_back(rd);
      end
      clrm = (we && a == A_ISTAT) ? wd[6:0] : 7'h0;
      m_stat = (m_stat & ~clrm) | setv;
      if (we && a == A_IEN) m_ien = wd[6:0];
      if (we && a == A_TRAIL) m_trail = wd[3:0];
      if (we && a == A_CTRL) begin
         m_rxen = wd[0]; m_txen = wd[1]; m_rxtrig = wd[10:4]; m_txtrig = wd[22:16];
      end
      if (!m_txen) mtx.delete();
      if (!m_rxen) mrx.delete();
      @(posedge clk);
   endtask

   task automatic idle(input string tag);
      cyc(tag, 0, 0, 3'd0, 32'h0, 0, 0, 8'h00);
   endtask

   task automatic rd_reg(input string tag, input logic [2:0] a);
      cyc(tag, 0, 1, a, 32'h0, 0, 0, 8'h00);
   endtask

   task automatic wr_reg(input string tag, input logic [2:0] a, input logic [31:0] d);
      cyc(tag, 1, 0, a, d, 0, 0, 8'h00);
   endtask

   function automatic logic [31:0] ctrl_word(input bit rxen, input bit txen,
                                             input logic [6:0] rxt, input logic [6:0] txt);
      logic [31:0] w;
      w = '0; w[0] = rxen; w[1] = txen; w[10:4] = rxt; w[22:16] = txt;
      return w;
   endfunction

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'd7719));
      reg_we = 0; reg_re = 0; reg_addr = 0; reg_wdata = 0;
      eng_tx_pop = 0; eng_rx_push = 0; eng_rx_data = 0;
      m_txen = 0; m_rxen = 0; m_txtrig = 0; m_rxtrig = 0;
      m_ien = 0; m_stat = 0; m_trail = 0; m_tcnt = 0;
      rst_n = 0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R1: reset values
      rd_reg("R1 ctrl", A_CTRL);
      rd_reg("R1 stat", A_ISTAT);
      rd_reg("R1 ien", A_IEN);
      rd_reg("R1 trail", A_TRAIL);
      rd_reg("R1 fstat", A_FSTAT);
      chk("R1 fstat literal", reg_rdata, 32'h0100_0100);
      rd_reg("R10 addr5 zero", A_TXD);
      rd_reg("R10 addr7 zero", 3'd7);

      // R3: enable both, TX trigger 2, RX trigger 4
      wr_reg("R3", A_CTRL, ctrl_word(1, 1, 7'd4, 7'd2));
      wr_reg("R9", A_IEN, 32'h7F);
      wr_reg("R8", A_ISTAT, 32'h7F);
      rd_reg("R3 ctrl", A_CTRL);

      // R2 / R4: fill TX past full
      for (int i = 0; i < D + 1; i++) wr_reg("R4", A_TXD, 32'h30 + i);
      rd_reg("R2 fstat full", A_FSTAT);
      rd_reg("R4 tx overrun", A_ISTAT);
      chk("R4 tx overrun bit3", {31'b0, reg_rdata[3]}, 32'd1);

      // R4: simultaneous push and pop on full TX
      wr_reg("R8", A_ISTAT, 32'h08);
      cyc("R4", 1, 0, A_TXD, 32'hA5, 1, 0, 8'h00);
      rd_reg("R4 no overrun", A_ISTAT);
      chk("R4 bit3 clear", {31'b0, reg_rdata[3]}, 32'd0);

      // R2 / R5: drain TX in order, then pop empty
      for (int i = 0; i < D; i++) cyc("R2", 0, 0, 3'd0, 0, 1, 0, 8'h00);
      cyc("R5", 0, 0, 3'd0, 0, 1, 0, 8'h00);
      rd_reg("R5 tx underrun", A_ISTAT);
      chk("R5 tx underrun bit2", {31'b0, reg_rdata[2]}, 32'd1);

      // R5: push and pop on empty TX in the same cycle
      wr_reg("R8", A_ISTAT, 32'h04);
      cyc("R5", 1, 0, A_TXD, 32'h5A, 1, 0, 8'h00);
      rd_reg("R5 both", A_ISTAT);
      rd_reg("R5 level", A_FSTAT);

      // R8: clear TX almost-empty while it is still being set
      wr_reg("R8", A_ISTAT, 32'h01);
      rd_reg("R8 set wins", A_ISTAT);
      chk("R8 bit0 held", {31'b0, reg_rdata[0]}, 32'd1);
      wr_reg("R8", A_ISTAT, 32'h00);
      rd_reg("R8 zero write", A_ISTAT);

      // R6: trailing with limit 3 and 3 bytes below trigger 4
      wr_reg("R6", A_TRAIL, 32'h3);
      for (int i = 0; i < 3; i++) cyc("R6", 0, 0, 3'd0, 0, 0, 1, 8'hC0 + 8'(i));
      wr_reg("R8", A_ISTAT, 32'h7F);
      idle("R6"); idle("R6");
      rd_reg("R6 early", A_ISTAT);
      chk("R6 not yet", {31'b0, reg_rdata[6]}, 32'd0);
      idle("R6"); idle("R6");
      rd_reg("R6 fired", A_ISTAT);
      chk("R6 fired bit6", {31'b0, reg_rdata[6]}, 32'd1);

      // R7: RX almost-full once fill reaches 4
      cyc("R7", 0, 0, 3'd0, 0, 0, 1, 8'hC3);
      idle("R7");
      rd_reg("R7 rx af", A_ISTAT);
      chk("R7 bit1", {31'b0, reg_rdata[1]}, 32'd1);

      // R2 / R5: read RX in order, then underrun
      for (int i = 0; i < 5; i++) rd_reg("R2 rx data", A_RXD);
      rd_reg("R5 rx underrun", A_ISTAT);
      chk("R5 rx underrun bit4", {31'b0, reg_rdata[4]}, 32'd1);

      // R4: RX overrun
      for (int i = 0; i < D + 1; i++) cyc("R4", 0, 0, 3'd0, 0, 0, 1, 8'(i));
      rd_reg("R4 rx overrun", A_ISTAT);
      chk("R4 rx overrun bit5", {31'b0, reg_rdata[5]}, 32'd1);

      // R3: disabling flushes and ignores traffic
      wr_reg("R3", A_CTRL, ctrl_word(0, 1, 7'd4, 7'd2));
      wr_reg("R8", A_ISTAT, 32'h7F);
      cyc("R3", 0, 1, A_RXD, 0, 0, 1, 8'h99);
      rd_reg("R3 flushed", A_FSTAT);
      rd_reg("R3 no flags", A_ISTAT);
      chk("R3 rx flags clear", {30'b0, reg_rdata[5:4]}, 32'd0);
      wr_reg("R9", A_IEN, 32'h00);
      wr_reg("R3", A_CTRL, ctrl_word(1, 1, 7'd8, 7'd4));

      // random phase
      for (int n = 0; n < 5000; n++) begin
         int r;
         bit tp, rp;
         logic [7:0] rb;
         r  = int'($urandom % 100);
         tp = ($urandom % 3) == 0;
         rp = ($urandom % 3) == 0;
         rb = 8'($urandom);
         if (r < 30)      cyc("R2", 1, 0, A_TXD, $urandom, tp, rp, rb);
         else if (r < 36) cyc("R8", 1, 0, A_ISTAT, $urandom, tp, rp, rb);
         else if (r < 39) cyc("R9", 1, 0, A_IEN, $urandom, tp, rp, rb);
         else if (r < 41) cyc("R3", 1, 0, A_CTRL,
                              ctrl_word(($urandom % 8) != 0, ($urandom % 8) != 0,
                                        7'($urandom % 20), 7'($urandom % 20)), tp, rp, rb);
         else if (r < 43) cyc("R6", 1, 0, A_TRAIL, $urandom, tp, rp, rb);
         else if (r < 63) cyc("R2", 0, 1, A_RXD, 0, tp, rp, rb);
         else if (r < 78) cyc("R10", 0, 1, 3'($urandom % 8), 0, tp, rp, rb);
         else             cyc("R7", 0, 0, 3'd0, 0, tp, rp, rb);
      end
      rd_reg("R10 final", A_FSTAT);
      summary();
   end
endmodule